// File: doc/BRIEF.md
# Multiply, Divide and Multiply-Accumulate Unit

This block is the arithmetic helper of a small controller whose registers are 16 bits wide and used in pairs. The core presents the current contents of its AX, BC, DE and HL registers together with an operation code and a one-cycle start pulse. The unit captures the operands, works for a fixed number of clocks that depends only on the operation, and then presents the new register values with a one-cycle done pulse. The core writes back only the registers that the operation produces. The 8-bit operands A and X are the upper and lower bytes of AX.

The unit offers five kinds of work. It does an 8x8 unsigned product, 16x16 signed and unsigned products, and unsigned division of 16 or 32 bits. Division uses a restoring divider that settles two quotient bits per clock. It also does signed or unsigned multiply-accumulate into a 32-bit accumulator that lives inside the block and can be read out. A zero divisor gives a defined result. Multiply-accumulate updates a carry and an auxiliary-carry flag.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 gives resAx = ax[15:8] * ax[7:0] (unsigned). done is high in the cycle after the 1st rising edge following the accepting edge.
- R2: Code 1 forms the signed product of ax and bc. resBc receives bits 31:16 and resAx bits 15:0. done follows 2 edges after the accepting edge.
- R3: Code 2 forms the unsigned product of ax and bc with the same placement and the same 2-edge latency.
- R4: Code 3 divides ax by de (unsigned). resAx receives the quotient and resDe the remainder. done follows 9 edges after the accepting edge.
- R5: For code 3 with de = 0, resAx is 0xFFFF and resDe equals ax.
- R6: Code 4 divides {bc,ax} by {hl,de}. The quotient goes to {resBc,resAx} and the remainder to {resHl,resDe}. done follows 17 edges after the accepting edge.
- R7: For code 4 with {hl,de} = 0, both resBc and resAx are 0xFFFF and {resHl,resDe} equals {bc,ax}.
- R8: Code 5 adds the signed product ax*bc to accOut, modulo 2^32. cyFlag is set when bit 31 of accOut changes, and acFlag takes the new bit 31. done follows 3 edges after the accepting edge.
- R9: Code 6 adds the unsigned product ax*bc to accOut, modulo 2^32. cyFlag is set when the new value is below the old one, and acFlag is cleared. The latency is 3 edges.
- R10: A start while busy is high is ignored. The running operation finishes with its own results and latency. busy is high from the accepting edge until the edge that raises done, and done lasts one cycle.
- R11: After reset, busy, done, all result outputs, accOut and both flags are zero.
- R12: Result registers that an operation does not produce keep their values. cyFlag and acFlag change only on codes 5 and 6.
- R13: Code 7 is reserved. A start with it does not raise busy or done and changes no output.
- R14: Operands are captured on the accepting edge. Changes on ax, bc, de and hl after that edge do not alter the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin the operation in opSel |
| opSel | input | 3 | Operation code (0 to 6; 7 reserved) |
| ax | input | 16 | AX operand (A = upper byte, X = lower byte) |
| bc | input | 16 | BC operand |
| de | input | 16 | DE operand |
| hl | input | 16 | HL operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| resAx | output | 16 | New AX value |
| resBc | output | 16 | New BC value |
| resDe | output | 16 | New DE value |
| resHl | output | 16 | New HL value |
| accOut | output | 32 | Multiply-accumulate register |
| cyFlag | output | 1 | Carry flag |
| acFlag | output | 1 | Auxiliary-carry flag |

## Verification
Each result is due a fixed number of rising edges after the edge that accepts start. That number is 1 for the byte product, 2 for the word products, 3 for multiply-accumulate, 9 for the short division and 17 for the long division. The bench counts those edges one at a time and samples on falling edges. At every intermediate sample it confirms that done is low and busy is high. It then checks done, busy and every output at the falling edge right after the due edge. Stray start pulses and changes to the operands are injected during long operations, so a wrong latency, an early done or a second acceptance shows up as a mismatch.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL8  = 3'd0,
    OP_MULS  = 3'd1,
    OP_MULU  = 3'd2,
    OP_DIVN  = 3'd3,
    OP_DIVW  = 3'd4,
    OP_MACS  = 3'd5,
    OP_MACU  = 3'd6,
    OP_NONE  = 3'd7
  } mdu_op_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic    load;    // capture operands
    logic    step;    // advance the divider
    logic    commit;  // write results
    mdu_op_e op;      // operation in flight (or being loaded)
  } mdu_strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BITS_PER_STEP = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  opSel,
  output mdu_strobe_t strb,
  output logic        busy,
  output logic        done
);

  localparam int LAT_DIVN = DATA_W / BITS_PER_STEP + 1;
  localparam int LAT_DIVW = 2 * DATA_W / BITS_PER_STEP + 1;
  localparam int LAT_MUL8 = 1;
  localparam int LAT_MULW = 2;
  localparam int LAT_MAC  = 3;
  localparam int CNT_W    = $clog2(LAT_DIVW + 1);

  mdu_op_e          opReg;
  mdu_op_e          opIn;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             isDiv;

  function automatic int latencyOf(mdu_op_e op);
    case (op)
      OP_MUL8:          return LAT_MUL8;
      OP_MULS, OP_MULU: return LAT_MULW;
      OP_DIVN:          return LAT_DIVN;
      OP_DIVW:          return LAT_DIVW;
      OP_MACS, OP_MACU: return LAT_MAC;
      default:          return 1;
    endcase
  endfunction

  assign opIn   = mdu_op_e'(opSel);
  assign accept = start && !busy && (opIn != OP_NONE);
  assign isDiv  = (opReg == OP_DIVN) || (opReg == OP_DIVW);

  always_comb begin
    strb.load   = accept;
    strb.step   = busy && (cnt != '0) && isDiv;
    strb.commit = busy && (cnt == '0);
    strb.op     = accept ? opIn : opReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      opReg <= OP_NONE;
    end else begin
      done <= strb.commit;
      if (accept) begin
        busy  <= 1'b1;
        opReg <= opIn;
        cnt   <= CNT_W'(latencyOf(opIn) - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // R10: done is a single-cycle pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: busy drops only on the edge that raises done
  assert_busy_until_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));
  // R10: a start while busy cannot restart the count
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  // R13: the reserved code never raises busy
  assert_reserved_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && opSel == 3'd7) |=> !busy);

endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BITS_PER_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdu_strobe_t       strb,
  input  logic [DATA_W-1:0] ax,
  input  logic [DATA_W-1:0] bc,
  input  logic [DATA_W-1:0] de,
  input  logic [DATA_W-1:0] hl,
  output logic [DATA_W-1:0] resAx,
  output logic [DATA_W-1:0] resBc,
  output logic [DATA_W-1:0] resDe,
  output logic [DATA_W-1:0] resHl,
  output logic [2*DATA_W-1:0] accOut,
  output logic              cyFlag,
  output logic              acFlag
);

  localparam int WIDE = 2 * DATA_W;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] opA, opB;
  logic [WIDE-1:0]   quoR, remR, dvsR;
  logic [WIDE-1:0]   accR;
  logic [DATA_W-1:0] prodByte;
  logic [WIDE-1:0]   prodS, prodU;
  logic [WIDE-1:0]   macSumS, macSumU;

  // Products from the captured operands
  assign prodByte = {{HALF{1'b0}}, opA[DATA_W-1:HALF]} * {{HALF{1'b0}}, opA[HALF-1:0]};
  assign prodS    = $signed({{DATA_W{opA[DATA_W-1]}}, opA}) * $signed({{DATA_W{opB[DATA_W-1]}}, opB});
  assign prodU    = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};
  assign macSumS  = accR + prodS;
  assign macSumU  = accR + prodU;

  // Restoring divider: BITS_PER_STEP quotient bits per clock
  logic [WIDE-1:0] remChain [0:BITS_PER_STEP];
  logic [WIDE-1:0] quoChain [0:BITS_PER_STEP];
  assign remChain[0] = remR;
  assign quoChain[0] = quoR;

  for (genvar i = 0; i < BITS_PER_STEP; i++) begin : g_divBit
    logic [WIDE:0] trial;
    logic [WIDE:0] diff;
    logic          fits;
    assign trial = {remChain[i], quoChain[i][WIDE-1]};
    assign diff  = trial - {1'b0, dvsR};
    assign fits  = trial >= {1'b0, dvsR};
    assign remChain[i+1] = fits ? diff[WIDE-1:0] : trial[WIDE-1:0];
    assign quoChain[i+1] = {quoChain[i][WIDE-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA    <= '0;
      opB    <= '0;
      quoR   <= '0;
      remR   <= '0;
      dvsR   <= '0;
      accR   <= '0;
      resAx  <= '0;
      resBc  <= '0;
      resDe  <= '0;
      resHl  <= '0;
      cyFlag <= 1'b0;
      acFlag <= 1'b0;
    end else begin
      if (strb.load) begin
        opA  <= ax;
        opB  <= bc;
        remR <= '0;
        if (strb.op == OP_DIVW) begin
          quoR <= {bc, ax};
          dvsR <= {hl, de};
        end else begin
          quoR <= {ax, {DATA_W{1'b0}}};
          dvsR <= {{DATA_W{1'b0}}, de};
        end
      end else if (strb.step) begin
        quoR <= quoChain[BITS_PER_STEP];
        remR <= remChain[BITS_PER_STEP];
      end

      if (strb.commit) begin
        case (strb.op)
          OP_MUL8: resAx <= prodByte;
          OP_MULS: begin
            resBc <= prodS[WIDE-1:DATA_W];
            resAx <= prodS[DATA_W-1:0];
          end
          OP_MULU: begin
            resBc <= prodU[WIDE-1:DATA_W];
            resAx <= prodU[DATA_W-1:0];
          end
          OP_DIVN: begin
            resAx <= quoR[DATA_W-1:0];
            resDe <= remR[DATA_W-1:0];
          end
          OP_DIVW: begin
            resBc <= quoR[WIDE-1:DATA_W];
            resAx <= quoR[DATA_W-1:0];
            resHl <= remR[WIDE-1:DATA_W];
            resDe <= remR[DATA_W-1:0];
          end
          OP_MACS: begin
            accR   <= macSumS;
            cyFlag <= accR[WIDE-1] ^ macSumS[WIDE-1];
            acFlag <= macSumS[WIDE-1];
          end
          OP_MACU: begin
            accR   <= macSumU;
            cyFlag <= macSumU < accR;
            acFlag <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign accOut = accR;

  // R4: a short division leaves a remainder below a nonzero divisor
  assert_div_rem_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_DIVN && dvsR != '0) |=> (resDe < $past(dvsR[DATA_W-1:0])));
  // R5: short division by zero yields an all-ones quotient
  assert_divzero_quot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_DIVN && dvsR == '0) |=> (resAx == {DATA_W{1'b1}}));
  // R8: signed accumulate copies the new sign into the auxiliary flag
  assert_macs_sign_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_MACS) |=> (acFlag == accOut[WIDE-1]));
  // R9: unsigned accumulate clears the auxiliary flag
  assert_macu_ac_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.op == OP_MACU) |=> !acFlag);
  // R12: flags hold across non-accumulate operations
  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!(strb.commit && (strb.op == OP_MACS || strb.op == OP_MACU))) |=> ($stable(cyFlag) && $stable(acFlag)));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int BITS_PER_STEP = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opSel,
  input  logic [DATA_W-1:0]   ax,
  input  logic [DATA_W-1:0]   bc,
  input  logic [DATA_W-1:0]   de,
  input  logic [DATA_W-1:0]   hl,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   resAx,
  output logic [DATA_W-1:0]   resBc,
  output logic [DATA_W-1:0]   resDe,
  output logic [DATA_W-1:0]   resHl,
  output logic [2*DATA_W-1:0] accOut,
  output logic                cyFlag,
  output logic                acFlag
);

  mdu_strobe_t strb;

  mdu_ctrl #(.DATA_W(DATA_W), .BITS_PER_STEP(BITS_PER_STEP)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  mdu_dp #(.DATA_W(DATA_W), .BITS_PER_STEP(BITS_PER_STEP)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .ax     (ax),
    .bc     (bc),
    .de     (de),
    .hl     (hl),
    .resAx  (resAx),
    .resBc  (resBc),
    .resDe  (resDe),
    .resHl  (resHl),
    .accOut (accOut),
    .cyFlag (cyFlag),
    .acFlag (acFlag)
  );

endmodule

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [15:0] ax = '0, bc = '0, de = '0, hl = '0;
  logic        busy, done, cyFlag, acFlag;
  logic [15:0] resAx, resBc, resDe, resHl;
  logic [31:0] accOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  // expected model state
  logic [15:0] eAx = '0, eBc = '0, eDe = '0, eHl = '0;
  logic [31:0] eAcc = '0;
  logic        eCy = 1'b0, eAc = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .ax(ax), .bc(bc), .de(de), .hl(hl),
    .busy(busy), .done(done),
    .resAx(resAx), .resBc(resBc), .resDe(resDe), .resHl(resHl),
    .accOut(accOut), .cyFlag(cyFlag), .acFlag(acFlag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check({resAx, resBc, resDe, resHl, accOut, cyFlag, acFlag} ==
          {eAx, eBc, eDe, eHl, eAcc, eCy, eAc}, req, "outputs",
          {resAx, resBc, resDe, resHl, accOut, cyFlag, acFlag},
          {eAx, eBc, eDe, eHl, eAcc, eCy, eAc});
  endtask

  task automatic runOp(input logic [2:0] op, input logic [15:0] a, b, d, h,
                       input bit poke, input string req);
    int lat;
    bit early;
    logic [63:0] p;
    logic [31:0] nw, dvd, dvs;
    longint sa, sb;
    early = 0;
    case (op)
      3'd0: begin lat = 1; eAx = 16'(a[15:8] * a[7:0]); end
      3'd1: begin
        lat = 2; sa = longint'($signed(a)); sb = longint'($signed(b));
        p = 64'(sa * sb); eBc = p[31:16]; eAx = p[15:0];
      end
      3'd2: begin lat = 2; p = 64'(a) * 64'(b); eBc = p[31:16]; eAx = p[15:0]; end
      3'd3: begin
        lat = 9;
        if (d == 0) begin eAx = 16'hFFFF; eDe = a; end
        else begin eAx = a / d; eDe = a % d; end
      end
      3'd4: begin
        lat = 17; dvd = {b, a}; dvs = {h, d};
        if (dvs == 0) begin eBc = 16'hFFFF; eAx = 16'hFFFF; {eHl, eDe} = dvd; end
        else begin {eBc, eAx} = dvd / dvs; {eHl, eDe} = dvd % dvs; end
      end
      3'd5: begin
        lat = 3; sa = longint'($signed(a)); sb = longint'($signed(b));
        p = 64'(sa * sb); nw = eAcc + p[31:0];
        eCy = eAcc[31] ^ nw[31]; eAc = nw[31]; eAcc = nw;
      end
      default: begin
        lat = 3; p = 64'(a) * 64'(b); nw = eAcc + p[31:0];
        eCy = nw < eAcc; eAc = 1'b0; eAcc = nw;
      end
    endcase
    @(negedge clk);
    start = 1'b1; opSel = op; ax = a; bc = b; de = d; hl = h;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    ax = ~a; bc = ~b; de = ~d; hl = ~h;  // R14: operands already captured
    for (int k = 1; k <= lat; k++) begin
      if (done || !busy) early = 1;
      start = 1'b0;
      if (poke && k == 2 && lat > 3) begin start = 1'b1; opSel = 3'd0; end
      @(posedge clk);
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy && !early, req, "done timing R10",
          {early, done, busy}, 3'b010);
    checkState({req, "/R12/R14"});
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1;
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] r1, r2, r3, r4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    check({busy, done} == 2'b00, "R11", "busy/done", {busy, done}, 0);
    checkState("R11");

    // R1 byte product sweep
    for (int a = 0; a < 256; a += 5)
      foreach (r1[i]) if (i < 5)
        runOp(3'd0, {8'(a), (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : (i == 2) ? 8'd127 : (i == 3) ? 8'd128 : 8'd255},
              16'h1234, 16'h5678, 16'h9ABC, 0, "R1");
    runOp(3'd0, 16'hFFFF, 0, 0, 0, 0, "R1");

    // R2 / R3 word products incl. corners
    runOp(3'd1, 16'h8000, 16'h8000, 0, 0, 0, "R2");
    runOp(3'd1, 16'hFFFF, 16'h0001, 0, 0, 0, "R2");
    runOp(3'd1, 16'h7FFF, 16'h8000, 0, 0, 0, "R2");
    runOp(3'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R3");
    for (int i = 0; i < 60; i++) begin
      r1 = 16'($urandom); r2 = 16'($urandom);
      runOp(3'd1, r1, r2, 16'($urandom), 16'($urandom), 0, "R2");
      runOp(3'd2, r1, r2, 16'($urandom), 16'($urandom), 0, "R3");
    end

    // R4 / R5 short division
    runOp(3'd3, 16'h1234, 16'h1111, 16'h0000, 16'h2222, 0, "R5");
    runOp(3'd3, 16'hFFFF, 0, 16'h0000, 0, 0, "R5");
    runOp(3'd3, 16'hFFFF, 0, 16'hFFFF, 0, 1, "R4");
    runOp(3'd3, 16'h0005, 0, 16'h0007, 0, 0, "R4");
    runOp(3'd3, 16'hFFFF, 0, 16'h0001, 0, 0, "R4");
    for (int i = 0; i < 120; i++) begin
      r3 = 16'($urandom);
      if (i % 3 == 0) r3 = r3 >> (i % 16);
      runOp(3'd3, 16'($urandom), 16'($urandom), r3, 16'($urandom), i % 7 == 0, "R4");
    end

    // R6 / R7 long division
    runOp(3'd4, 16'h5678, 16'h1234, 16'h0000, 16'h0000, 0, "R7");
    runOp(3'd4, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 1, "R7");
    runOp(3'd4, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 0, "R6");
    runOp(3'd4, 16'h0000, 16'h8000, 16'hFFFF, 16'hFFFF, 0, "R6");
    for (int i = 0; i < 80; i++) begin
      r3 = 16'($urandom); r4 = 16'($urandom);
      if (i % 2 == 0) r4 = r4 >> (i % 17);
      runOp(3'd4, 16'($urandom), 16'($urandom), r3, r4, i % 5 == 0, "R6");
    end

    // R8 / R9 accumulate, including sign changes and wraparound
    runOp(3'd5, 16'h7FFF, 16'h7FFF, 0, 0, 0, "R8");
    runOp(3'd5, 16'h7FFF, 16'h7FFF, 0, 0, 0, "R8");
    runOp(3'd5, 16'h8000, 16'h7FFF, 0, 0, 0, "R8");
    runOp(3'd6, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R9");
    runOp(3'd6, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R9");
    runOp(3'd6, 16'h0000, 16'h1234, 0, 0, 0, "R9");
    for (int i = 0; i < 60; i++) begin
      runOp(3'd5, 16'($urandom), 16'($urandom), 0, 0, 0, "R8");
      runOp(3'd6, 16'($urandom), 16'($urandom), 0, 0, 0, "R9");
    end

    // R13: reserved code does nothing
    @(negedge clk);
    start = 1'b1; opSel = 3'd7; ax = 16'hAAAA; bc = 16'h5555;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done, "R13", "busy/done after reserved", {busy, done}, 0);
    repeat (3) @(negedge clk);
    check(!busy && !done, "R13", "busy/done later", {busy, done}, 0);
    checkState("R13");

    // R10: back-to-back operations after done
    runOp(3'd0, 16'h0203, 0, 0, 0, 0, "R10");
    runOp(3'd4, 16'h0100, 16'h0000, 16'h0003, 16'h0000, 1, "R10");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule